// File: doc/BRIEF.md
# Split-Row Byte-Lane Word Memory

This block is a 32-bit read/write memory that accepts any byte address, aligned or not, and completes a full word access in a single cycle. Storage is divided into four byte-wide banks, one per byte lane. The byte address splits into a row, which is the upper bits, and a byte offset, which is `addr[1:0]`. Byte lane `i` holds every byte whose address modulo 4 equals `i`.

An aligned word uses the same row in every bank. For a word that starts at offset `k`, the word spills into the following row. The banks of the lanes numbered below `k` are therefore each given the row plus one, while the other banks keep the presented row. All four banks are read or written in the same clock edge.

Write data and byte enables are rotated toward the lanes before the banks see them. Read data is rotated back, so the byte at the start address always appears in bits 7:0. Seen from the ports, the block acts as a byte array of `4 << ROW_W` entries in which word byte `j` lives at byte address `(addr + j) mod size`.

Top module: `split_row_mem`

## Requirements
- R1: An aligned word (offset `addr[1:0]` = 0) that is written with all four enables set reads back unchanged from the same address.
- R2: A read is requested with `en`=1 and `we`=0. Its data appears on `rdata` in the next cycle, and `rvalid` is 1 in exactly that cycle. `rvalid` is 0 in every cycle that follows a cycle without a read request.
- R3: A write with `en`=1 and `we`=1 at offset 1, 2 or 3 completes in one cycle. It stores `wdata[8j+7:8j]` at byte address `addr+j` for j = 0..3, which reaches into the next row.
- R4: A read at offset 1, 2 or 3 returns, in one cycle, the bytes at `addr..addr+3`. The byte at `addr` is in `rdata[7:0]` and the byte at `addr+3` is in `rdata[31:24]`.
- R5: Write enable bit `wbe[j]` gates word byte `j`, which is the byte written to `addr+j`. A byte whose enable is 0 keeps its previous contents.
- R6: A byte address past the top of the memory wraps to the bottom: `addr+j` is taken modulo `4 << ROW_W`. When the last row is accessed at a nonzero offset, the carried lanes use row 0.
- R7: While `en`=0, the memory contents do not change whatever `we`, `wdata` and `wbe` are, `rvalid` stays 0 and `rdata` holds its value.
- R8: A synchronous active-low reset clears `rvalid` and `rdata` to 0. It leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W+2 | Byte start address: row in the upper bits, lane offset in bits 1:0 |
| wdata | input | 32 | Write word, with byte 0 destined for the start address |
| wbe | input | 4 | Per-byte write enables, relative to the start address |
| rdata | output | 32 | Read word, with the start byte in bits 7:0 |
| rvalid | output | 1 | High in the cycle after a read request |

## Verification
The interesting coincidence is the lane carry and the wrap falling in the same cycle. This happens on an access to the last row at a nonzero offset: some lanes must step to the next row, and that next row is row 0. The bench writes and reads every byte address with every enable pattern, so the last three addresses of the memory provoke this case for each offset and mask. Each result is judged against a byte-array model in which byte `j` goes to `(addr+j) mod size`. A second coincidence, rotated enables meeting the carried row, is covered by the same sweep: a partial mask at an unaligned address must touch only the chosen bytes, in both rows.

// File: rtl/split_row_pkg.sv
// Shared constants and helpers for the split-row memory.
// Assumes a fixed 32-bit word built from four 8-bit lanes.
package split_row_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef logic [LANES-1:0][BYTE_W-1:0] lane_bytes_t;

    // Lane-to-word byte index: which word byte lands on lane i at offset k.
    function automatic logic [OFF_W-1:0] word_idx(input logic [OFF_W-1:0] lane,
                                                  input logic [OFF_W-1:0] k);
        return lane - k;
    endfunction
endpackage

// File: rtl/lane_bank.sv
// One byte-wide bank with a registered read port.
// Assumes write and read are never requested together for the same bank.
// Contents are not reset; only the read register is.
module lane_bank #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [ROW_W-1:0] row,
    input  logic [7:0]       din,
    output logic [7:0]       dout
);
    localparam int DEPTH = 1 << ROW_W;

    logic [7:0] cells [DEPTH];

    // Store the lane byte at its row.
    always_ff @(posedge clk) begin
        if (wr_en) cells[row] <= din;
    end

    // Capture the selected row on a read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     dout <= '0;
        else if (rd_en) dout <= cells[row];
    end

    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(dout));
endmodule

// File: rtl/row_steer.sv
// Works out each lane's row and routes write bytes and enables to lanes.
// Purely combinational. The lanes below the offset take the row plus one,
// and the row wraps modulo 2**ROW_W.
module row_steer
    import split_row_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input  logic [ROW_W-1:0]            base_row,
    input  logic [OFF_W-1:0]            off,
    input  logic [WORD_W-1:0]           wdata,
    input  logic [LANES-1:0]            wbe,
    output logic [LANES-1:0]            plus_one,
    output logic [LANES-1:0][ROW_W-1:0] lane_row,
    output lane_bytes_t                 lane_din,
    output logic [LANES-1:0]            lane_be
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OFF_W-1:0] src;

        // Decide the carry, the row and the routed byte for lane i.
        always_comb begin
            plus_one[i] = OFF_W'(i) < off;
            lane_row[i] = base_row + ROW_W'(plus_one[i]);
            src         = word_idx(OFF_W'(i), off);
            lane_din[i] = wdata[src*BYTE_W +: BYTE_W];
            lane_be[i]  = wbe[src];
        end
    end
endmodule

// File: rtl/read_align.sv
// Rotates the registered lane outputs so the start byte lands in bits 7:0.
// Remembers the offset of the last read, so the output stays put between reads.
module read_align
    import split_row_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [OFF_W-1:0]  off,
    input  lane_bytes_t       lane_dout,
    output logic [WORD_W-1:0] rdata
);
    logic [OFF_W-1:0] off_q;

    // Keep the offset that goes with the bank outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)     off_q <= '0;
        else if (rd_en) off_q <= off;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_out
        logic [OFF_W-1:0] lane;
        assign lane = OFF_W'(j) + off_q;
        assign rdata[j*BYTE_W +: BYTE_W] = lane_dout[lane];
    end
endmodule

// File: rtl/split_row_mem.sv
// Byte-addressable 32-bit memory. Any start address completes in one cycle:
// the lanes below the offset use the next row. Reads have one cycle of latency.
// Assumes en/we/addr are synchronous to clk.
module split_row_mem
    import split_row_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   we,
    input  logic [ROW_W+OFF_W-1:0] addr,
    input  logic [WORD_W-1:0]      wdata,
    input  logic [LANES-1:0]       wbe,
    output logic [WORD_W-1:0]      rdata,
    output logic                   rvalid
);
    logic [ROW_W-1:0]            base_row;
    logic [OFF_W-1:0]            off;
    logic [LANES-1:0]            plus_one;
    logic [LANES-1:0][ROW_W-1:0] lane_row;
    lane_bytes_t                 lane_din;
    lane_bytes_t                 lane_dout;
    logic [LANES-1:0]            lane_be;
    logic                        rd_req;
    logic                        wr_req;

    assign base_row = addr[ROW_W+OFF_W-1:OFF_W];
    assign off      = addr[OFF_W-1:0];
    assign rd_req   = en && !we;
    assign wr_req   = en && we;

    row_steer #(.ROW_W(ROW_W)) u_steer (
        .base_row (base_row),
        .off      (off),
        .wdata    (wdata),
        .wbe      (wbe),
        .plus_one (plus_one),
        .lane_row (lane_row),
        .lane_din (lane_din),
        .lane_be  (lane_be)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_bank
        lane_bank #(.ROW_W(ROW_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_req && lane_be[i]),
            .rd_en (rd_req),
            .row   (lane_row[i]),
            .din   (lane_din[i]),
            .dout  (lane_dout[i])
        );
    end

    read_align u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_req),
        .off       (off),
        .lane_dout (lane_dout),
        .rdata     (rdata)
    );

    // Flag the cycle that carries read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rvalid <= 1'b0;
        else        rvalid <= rd_req;
    end

    assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);
    assert_rvalid_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid);
    assert_carry_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ($countones(plus_one) == int'(off)));
    assert_be_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ($countones(lane_be) == $countones(wbe)));
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && off != '0 && base_row == '1) |-> (lane_row[0] == '0));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rdata));
endmodule

// File: tb/split_row_mem_tb.sv
// Exhaustive sweep against a byte-array model: every address, every enable mask.
module split_row_mem_tb;
    localparam int ROW_W  = 4;
    localparam int AW     = ROW_W + 2;
    localparam int NBYTES = 4 << ROW_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [3:0]    wbe = '0;
    logic [31:0]   rdata;
    logic          rvalid;

    logic [7:0] model [NBYTES];
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    split_row_mem #(.ROW_W(ROW_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr),
        .wdata(wdata), .wbe(wbe), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input int a);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) w[j*8 +: 8] = model[(a + j) % NBYTES];
        return w;
    endfunction

    task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        en = 1'b1; we = 1'b1; addr = AW'(a); wdata = d; wbe = be;
        @(negedge clk);
        en = 1'b0; we = 1'b0;
        for (int j = 0; j < 4; j++)
            if (be[j]) model[(a + j) % NBYTES] = d[j*8 +: 8];
    endtask

    task automatic do_read(input int a, input string req);
        @(negedge clk);
        en = 1'b1; we = 1'b0; addr = AW'(a);
        @(negedge clk);
        en = 1'b0;
        check("R2 rvalid after read", {31'b0, rvalid}, 32'd1);
        check(req, rdata, expect_word(a));
        @(negedge clk);
        check("R2 rvalid idle", {31'b0, rvalid}, 32'd0);
    endtask

    function automatic string tag_of(input int a);
        if (a + 3 >= NBYTES) return "R6 wrap";
        if (a % 4 != 0)      return "R3/R4/R5 unaligned";
        return "R1/R5 aligned";
    endfunction

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] hold;
        repeat (3) @(negedge clk);
        check("R8 reset rvalid", {31'b0, rvalid}, 32'd0);
        check("R8 reset rdata", rdata, 32'd0);
        rst_n = 1'b1;

        // R1: fill with aligned full words, then read back.
        for (int r = 0; r < NBYTES / 4; r++)
            do_write(r * 4, 32'h9E3779B9 * (r + 7), 4'hF);
        for (int r = 0; r < NBYTES / 4; r++)
            do_read(r * 4, "R1 aligned readback");

        // R4/R6: read at every byte address.
        for (int a = 0; a < NBYTES; a++)
            do_read(a, (a + 3 >= NBYTES) ? "R6 wrap read" : "R4 unaligned read");

        // R3/R5/R6: every address with every mask, read back after each.
        for (int a = 0; a < NBYTES; a++)
            for (int m = 0; m < 16; m++) begin
                do_write(a, 32'h85EBCA6B * (a * 16 + m + 1), 4'(m));
                do_read(a, tag_of(a));
            end

        // R7: en low with write-looking inputs changes nothing.
        do_read(5, "R7 before idle");
        hold = rdata;
        @(negedge clk);
        we = 1'b1; addr = AW'(5); wdata = 32'hFFFF_FFFF; wbe = 4'hF;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R7 rvalid stays low", {31'b0, rvalid}, 32'd0);
            check("R7 rdata holds", rdata, hold);
        end
        we = 1'b0;
        do_read(5, "R7 contents unchanged");

        // R8: reset clears outputs but keeps contents.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset rdata again", rdata, 32'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++)
            do_read(a * 7 % NBYTES, "R8 contents kept");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule